// File: doc/BRIEF.md
# Configuration Register Bank with Reset Classes

This block stores the bias, threshold and output-configuration settings of a pixel readout front end, plus two single-bit control flags and a timestamp capture register. A separate command decoder delivers one command per clock cycle as a valid strobe, a 3-bit operation code and a 5-bit register number. After a write command, the decoder streams the data one bit per cycle. The bank applies each command to the addressed register, or to every 8-bit register when the broadcast number is used. Read data leaves the block serially through a shadow register.

Some register numbers hold no storage and act as commands instead. Setting one of them restores all 8-bit settings to their safe defaults. Setting another issues a one-cycle request that clears the external crossing counter. The hardware reset loads every default. Operation-level resets outside the bank do not reach it at all. Setting the capture register samples the external crossing counter, and a status bit reports whether the sample was nonzero, which means the counter was out of step.

Top module: `cfg_bank`

## Requirements
- R1: After the synchronous active-low reset, addresses 1..7 read 100, 74, 29, 13, 202, 172, 8. Addresses 9..14 read 8. Addresses 8 and 15 read 0. The 2-bit output configuration is 0, the send flag is 0, the reject flag is 1, and the sync-error bit, the read bit and the counter-clear request are 0.
- R2: A write command (operation code 001) to address 1..7, 9..15 or 16 is followed by data bits, one per cycle with `data_valid` high. The first bit lands in bit 0 of the register. An 8-bit register takes 8 bits and address 16 takes 2 bits. Further bits are ignored.
- R3: Set (010) makes an 8-bit register all ones and address 16 equal to 3. Clear (101) makes either register 0. Default (110) restores the R1 value of either register. Each takes effect at the clock edge that samples the command.
- R4: A set to address 15 loads `bco_count` into that register. At the same edge, `sync_err` becomes 1 if the loaded value is nonzero and 0 if it is zero.
- R5: The send flag (address 19) and the reject flag (address 20) change only by set, which gives 1, and by clear, which gives 0. Write and default leave them unchanged, and a read of either address returns zeros.
- R6: A read (100) copies the addressed value into an 8-bit shadow. From the cycle after the command, `rd_bit` shows the most significant bit, and each cycle with `rd_shift` high advances to the next lower bit. Address 16 appears as its 2 bits followed by zeros. Addresses with no readable storage (0, 8, 17..31) return zeros.
- R7: A set to address 24 restores addresses 1..15 to their R1 values and leaves address 16 and both flags unchanged.
- R8: A set to address 28 raises `bco_clear` for exactly the one cycle after the command and changes no register.
- R9: Register number 21 applies write, set, clear or default to every 8-bit register (1..7, 9..15), with set on 15 still capturing the counter. Address 16 and both flags are left unchanged.
- R10: A command arriving while a write is still taking data ends that write. A data bit presented in the same cycle as the command, and any data bits after it, are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low full reset |
| cmd_valid | input | 1 | Command strobe from the decoder |
| cmd_op | input | 3 | Operation code (001 write, 010 set, 100 read, 101 clear, 110 default) |
| cmd_addr | input | 5 | Register number |
| data_valid | input | 1 | Write data bit is present |
| data_bit | input | 1 | Serial write data, least significant bit first |
| bco_count | input | 8 | Current crossing counter value |
| rd_shift | input | 1 | Advance the read shadow by one bit |
| dac_regs | output | 15x8 | Contents of addresses 1..15, element 0 is address 1 |
| out_cfg | output | 2 | Output-configuration register (address 16) |
| send_en | output | 1 | Send flag (address 19) |
| reject_hits | output | 1 | Reject flag (address 20) |
| sync_err | output | 1 | Last capture was nonzero |
| bco_clear | output | 1 | One-cycle request to clear the crossing counter |
| rd_bit | output | 1 | Serial read data, most significant bit first |

## Verification
The case most likely to go wrong is a write still in progress when the next command arrives. In that cycle, a data shift and a command-driven update both want the same registers. The bench provokes this by presenting a data bit together with a set command to a different register, and then a further data bit after it. It judges the result from the partially shifted value left in the first register and the all-ones value in the second. A second overlap is a broadcast set: it makes the all-ones loads and the counter capture happen in the same edge, and the bench checks both results.

// File: rtl/cfg_bank_pkg.sv
// Shared operation codes, special register numbers and reset values for the
// configuration register bank. Assumes 5-bit register numbers.
package cfg_bank_pkg;

    typedef enum logic [2:0] {
        OP_WRITE   = 3'b001,
        OP_SET     = 3'b010,
        OP_READ    = 3'b100,
        OP_CLEAR   = 3'b101,
        OP_DEFAULT = 3'b110
    } cfg_op_e;

    localparam logic [4:0] A_HOLE    = 5'd8;
    localparam logic [4:0] A_CAPTURE = 5'd15;
    localparam logic [4:0] A_OUTCFG  = 5'd16;
    localparam logic [4:0] A_SEND    = 5'd19;
    localparam logic [4:0] A_REJECT  = 5'd20;
    localparam logic [4:0] A_BCAST   = 5'd21;
    localparam logic [4:0] A_PROGRST = 5'd24;
    localparam logic [4:0] A_CORERST = 5'd28;

    // Safe value of each 8-bit setting, by register number
    function automatic logic [7:0] dac_default(input int a);
        case (a)
            1:       return 8'd100;
            2:       return 8'd74;
            3:       return 8'd29;
            4:       return 8'd13;
            5:       return 8'd202;
            6:       return 8'd172;
            7, 9, 10, 11, 12, 13, 14: return 8'd8;
            default: return 8'd0;
        endcase
    endfunction

endpackage

// File: rtl/cfg_byte_reg.sv
// One setting register. Set loads set_val_i (all ones, or the counter for the
// capture register), clear loads zero, default loads RST, and a write shifts
// serial data in from the top so the first bit ends at bit 0.
// Assumes at most one of set/clr/def is high per cycle; they beat shift.
module cfg_byte_reg #(
    parameter int          W   = 8,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_i,
    input  logic         clr_i,
    input  logic         def_i,
    input  logic [W-1:0] set_val_i,
    input  logic         shift_i,
    input  logic         shift_bit_i,
    output logic [W-1:0] q_o
);

    // Register update by priority: reset, command, serial load
    always_ff @(posedge clk) begin
        if (!rst_n)       q_o <= RST;
        else if (def_i)   q_o <= RST;
        else if (clr_i)   q_o <= '0;
        else if (set_i)   q_o <= set_val_i;
        else if (shift_i) q_o <= {shift_bit_i, q_o[W-1:1]};
    end

endmodule

// File: rtl/cfg_read_shadow.sv
// Read shadow: captures a value on load and presents it most significant bit
// first, moving one bit per cycle with shift. Assumes load wins over shift.
module cfg_read_shadow #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         shift_i,
    output logic         bit_o
);

    logic [W-1:0] shadow_q;

    // Capture on read, then move toward the output bit
    always_ff @(posedge clk) begin
        if (!rst_n)       shadow_q <= '0;
        else if (load_i)  shadow_q <= load_val_i;
        else if (shift_i) shadow_q <= {shadow_q[W-2:0], 1'b0};
    end

    assign bit_o = shadow_q[W-1];

endmodule

// File: rtl/cfg_bank.sv
// Configuration register bank. Applies one decoded command per cycle to the
// addressed register or to all 8-bit registers (broadcast), tracks an ongoing
// serial write, handles the command-only addresses (programming reset, core
// reset), and serializes reads. Assumes the decoder gives one command per cycle
// and that a new command cancels any write still taking data.
module cfg_bank
    import cfg_bank_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NREG = 15,
    parameter int CW   = 2,
    parameter int AW   = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_valid,
    input  logic [2:0]                cmd_op,
    input  logic [AW-1:0]             cmd_addr,
    input  logic                      data_valid,
    input  logic                      data_bit,
    input  logic [DW-1:0]             bco_count,
    input  logic                      rd_shift,
    output logic [NREG-1:0][DW-1:0]   dac_regs,
    output logic [CW-1:0]             out_cfg,
    output logic                      send_en,
    output logic                      reject_hits,
    output logic                      sync_err,
    output logic                      bco_clear,
    output logic                      rd_bit
);

    localparam int CNTW = $clog2(DW + 1);

    logic is_write, is_set, is_clr, is_def, is_read;
    logic hit_bc, prog_rst, writable, shift_go;
    logic wr_active;
    logic [AW-1:0]   wr_addr;
    logic [CNTW-1:0] wr_cnt, wr_len;
    logic [DW-1:0]   rd_val;

    // Command decode
    always_comb begin
        is_write = cmd_valid && (cmd_op == OP_WRITE);
        is_set   = cmd_valid && (cmd_op == OP_SET);
        is_clr   = cmd_valid && (cmd_op == OP_CLEAR);
        is_def   = cmd_valid && (cmd_op == OP_DEFAULT);
        is_read  = cmd_valid && (cmd_op == OP_READ);
        hit_bc   = (cmd_addr == A_BCAST);
        prog_rst = is_set && (cmd_addr == A_PROGRST);
        writable = ((cmd_addr >= AW'(1)) && (cmd_addr <= AW'(NREG)) && (cmd_addr != A_HOLE))
                   || (cmd_addr == A_OUTCFG) || hit_bc;
    end

    // Length of the write in progress and whether a data bit is taken now
    assign wr_len   = (wr_addr == A_OUTCFG) ? CNTW'(CW) : CNTW'(DW);
    assign shift_go = wr_active && data_valid && !cmd_valid;

    // Write tracker: any command restarts or ends it, data bits count it down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_active <= 1'b0;
            wr_addr   <= '0;
            wr_cnt    <= '0;
        end else if (cmd_valid) begin
            wr_active <= is_write && writable;
            wr_addr   <= cmd_addr;
            wr_cnt    <= '0;
        end else if (shift_go) begin
            wr_cnt <= wr_cnt + 1'b1;
            if (wr_cnt == wr_len - 1'b1) wr_active <= 1'b0;
        end
    end

    // 8-bit settings, one instance per address except the hole
    for (genvar i = 1; i <= NREG; i++) begin : g_reg
        localparam logic [AW-1:0] ADDR = AW'(i);
        if (ADDR == A_HOLE) begin : g_hole
            assign dac_regs[i-1] = '0;
        end else begin : g_store
            logic sel;
            assign sel = (cmd_addr == ADDR) || hit_bc;
            cfg_byte_reg #(
                .W   (DW),
                .RST (DW'(dac_default(i)))
            ) u_reg (
                .clk         (clk),
                .rst_n       (rst_n),
                .set_i       (is_set && sel),
                .clr_i       (is_clr && sel),
                .def_i       ((is_def && sel) || prog_rst),
                .set_val_i   ((ADDR == A_CAPTURE) ? bco_count : {DW{1'b1}}),
                .shift_i     (shift_go && ((wr_addr == ADDR) || (wr_addr == A_BCAST))),
                .shift_bit_i (data_bit),
                .q_o         (dac_regs[i-1])
            );
        end
    end

    // Output configuration: own address only, no broadcast, no programming reset
    always_ff @(posedge clk) begin
        if (!rst_n)                                        out_cfg <= '0;
        else if ((is_clr || is_def) && cmd_addr == A_OUTCFG) out_cfg <= '0;
        else if (is_set && cmd_addr == A_OUTCFG)             out_cfg <= '1;
        else if (shift_go && wr_addr == A_OUTCFG)            out_cfg <= {data_bit, out_cfg[CW-1:1]};
    end

    // Control flags: set and clear only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            send_en     <= 1'b0;
            reject_hits <= 1'b1;
        end else begin
            if (is_set && cmd_addr == A_SEND)   send_en     <= 1'b1;
            if (is_clr && cmd_addr == A_SEND)   send_en     <= 1'b0;
            if (is_set && cmd_addr == A_REJECT) reject_hits <= 1'b1;
            if (is_clr && cmd_addr == A_REJECT) reject_hits <= 1'b0;
        end
    end

    // Sync status follows each counter capture; core reset request pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_err  <= 1'b0;
            bco_clear <= 1'b0;
        end else begin
            if (is_set && (cmd_addr == A_CAPTURE || hit_bc)) sync_err <= (bco_count != '0);
            bco_clear <= is_set && (cmd_addr == A_CORERST);
        end
    end

    // Read source select, left-aligned so the top bit leaves first
    always_comb begin
        rd_val = '0;
        for (int i = 1; i <= NREG; i++)
            if (cmd_addr == AW'(i)) rd_val = dac_regs[i-1];
        if (cmd_addr == A_OUTCFG) rd_val = {out_cfg, {(DW-CW){1'b0}}};
    end

    cfg_read_shadow #(.W(DW)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (is_read),
        .load_val_i (rd_val),
        .shift_i    (rd_shift),
        .bit_o      (rd_bit)
    );

endmodule

// File: rtl/cfg_bank_chk.sv
// Temporal checks on the configuration register bank, bound to every instance.
// Assumes the port names of cfg_bank.
module cfg_bank_chk
    import cfg_bank_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NREG = 15,
    parameter int CW   = 2,
    parameter int AW   = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cmd_valid,
    input logic [2:0]              cmd_op,
    input logic [AW-1:0]           cmd_addr,
    input logic [DW-1:0]           bco_count,
    input logic [NREG-1:0][DW-1:0] dac_regs,
    input logic [CW-1:0]           out_cfg,
    input logic                    send_en,
    input logic                    reject_hits,
    input logic                    sync_err,
    input logic                    bco_clear,
    input logic                    rd_bit
);

    // R8
    core_clear_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_SET && cmd_addr == A_CORERST) |=> bco_clear);

    // R8
    core_clear_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_op == OP_SET && cmd_addr == A_CORERST) |=> !bco_clear);

    // R4
    capture_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_SET && cmd_addr == A_CAPTURE)
        |=> (sync_err == ($past(bco_count) != '0)) && (dac_regs[NREG-1] == $past(bco_count)));

    // R5
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && (cmd_op == OP_SET || cmd_op == OP_CLEAR)
          && (cmd_addr == A_SEND || cmd_addr == A_REJECT))
        |=> $stable(send_en) && $stable(reject_hits));

    // R6
    silent_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_READ
         && (cmd_addr == A_SEND || cmd_addr == A_REJECT || cmd_addr == '0))
        |=> !rd_bit);

    // R7
    prog_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_SET && cmd_addr == A_PROGRST)
        |=> (dac_regs[0] == DW'(dac_default(1))) && $stable(out_cfg));

    // R9
    bcast_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_SET && cmd_addr == A_BCAST)
        |=> (dac_regs[0] == '1) && $stable(out_cfg));

endmodule

bind cfg_bank cfg_bank_chk #(.DW(DW), .NREG(NREG), .CW(CW), .AW(AW)) u_chk (.*);

// File: tb/cfg_bank_bench.sv
`timescale 1ns/1ps
module cfg_bank_bench;

    localparam int DW = 8, NREG = 15, CW = 2, AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'b000;
    logic [AW-1:0] cmd_addr = '0;
    logic data_valid = 1'b0;
    logic data_bit = 1'b0;
    logic [DW-1:0] bco_count = '0;
    logic rd_shift = 1'b0;
    logic [NREG-1:0][DW-1:0] dac_regs;
    logic [CW-1:0] out_cfg;
    logic send_en, reject_hits, sync_err, bco_clear, rd_bit;

    int total = 0;
    int bad = 0;
    logic  exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    cfg_bank #(.DW(DW), .NREG(NREG), .CW(CW), .AW(AW)) u_cfg_bank (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Issue one command; returns at the negedge after it took effect
    task automatic cmd(input logic [2:0] op, input logic [AW-1:0] a);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; data_valid = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] v, input int n);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'b001; cmd_addr = a;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmd_valid = 1'b0; data_valid = 1'b1; data_bit = v[i];
        end
        @(negedge clk);
        data_valid = 1'b0;
    endtask

    // Driver: issue a read and push the expected serial bits to the scoreboard
    task automatic rd(input logic [AW-1:0] a, input logic [7:0] v, input int n, input string tag);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'b100; cmd_addr = a;
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(v[7-i]);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        cmd_valid = 1'b0; rd_shift = 1'b1;
        repeat (n - 1) @(negedge clk);
        rd_shift = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: compare each serial output bit against the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, {31'd0, rd_bit}, {31'd0, e});
            end
        end
    end

    // Watchdog
    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 addr1", dac_regs[0], 100);
        chk("R1 addr2", dac_regs[1], 74);
        chk("R1 addr5", dac_regs[4], 202);
        chk("R1 addr6", dac_regs[5], 172);
        chk("R1 addr7", dac_regs[6], 8);
        chk("R1 addr8", dac_regs[7], 0);
        chk("R1 addr14", dac_regs[13], 8);
        chk("R1 addr15", dac_regs[14], 0);
        chk("R1 outcfg", out_cfg, 0);
        chk("R1 send", send_en, 0);
        chk("R1 reject", reject_hits, 1);
        chk("R1 syncerr", sync_err, 0);
        chk("R1 clear", bco_clear, 0);
        chk("R1 rdbit", rd_bit, 0);

        // R2 write LSB first, R6 read back MSB first
        wr(5'd3, 8'hA5, 8);
        chk("R2 addr3", dac_regs[2], 8'hA5);
        rd(5'd3, 8'hA5, 8, "R6 read addr3");
        wr(5'd16, 8'b0000_0101, 3);
        chk("R2 outcfg extra bit ignored", out_cfg, 1);
        rd(5'd16, 8'b0100_0000, 3, "R6 read outcfg");

        // R3 set, clear, default
        cmd(3'b010, 5'd5);  chk("R3 set addr5", dac_regs[4], 255);
        cmd(3'b101, 5'd5);  chk("R3 clear addr5", dac_regs[4], 0);
        cmd(3'b110, 5'd5);  chk("R3 default addr5", dac_regs[4], 202);
        cmd(3'b010, 5'd16); chk("R3 set outcfg", out_cfg, 3);
        cmd(3'b110, 5'd16); chk("R3 default outcfg", out_cfg, 0);

        // R4 capture and sync status
        bco_count = 8'd0;  cmd(3'b010, 5'd15);
        chk("R4 capture zero", dac_regs[14], 0); chk("R4 sync zero", sync_err, 0);
        bco_count = 8'd37; cmd(3'b010, 5'd15);
        chk("R4 capture 37", dac_regs[14], 37);  chk("R4 sync set", sync_err, 1);
        bco_count = 8'd0;  cmd(3'b010, 5'd15);
        chk("R4 sync back to zero", sync_err, 0);

        // R5 flags
        cmd(3'b010, 5'd19); chk("R5 set send", send_en, 1);
        cmd(3'b101, 5'd20); chk("R5 clear reject", reject_hits, 0);
        wr(5'd19, 8'h00, 8); chk("R5 write ignored", send_en, 1);
        cmd(3'b110, 5'd20); chk("R5 default ignored", reject_hits, 0);
        rd(5'd19, 8'h00, 8, "R5 read send zeros");
        rd(5'd20, 8'h00, 2, "R5 read reject zeros");

        // R6 unused and forbidden addresses
        rd(5'd22, 8'h00, 8, "R6 read unused");
        rd(5'd0,  8'h00, 8, "R6 read forbidden");
        rd(5'd8,  8'h00, 8, "R6 read hole");

        // R7 programming reset
        wr(5'd1, 8'd7, 8);
        cmd(3'b010, 5'd12);
        cmd(3'b010, 5'd16);
        chk("R7 pre addr1", dac_regs[0], 7);
        cmd(3'b010, 5'd24);
        chk("R7 addr1", dac_regs[0], 100);
        chk("R7 addr3", dac_regs[2], 29);
        chk("R7 addr12", dac_regs[11], 8);
        chk("R7 outcfg kept", out_cfg, 3);
        chk("R7 send kept", send_en, 1);
        chk("R7 reject kept", reject_hits, 0);

        // R8 core reset request
        cmd(3'b010, 5'd28);
        chk("R8 clear high", bco_clear, 1);
        @(negedge clk);
        chk("R8 clear low", bco_clear, 0);
        chk("R8 regs kept", dac_regs[0], 100);

        // R9 broadcast
        bco_count = 8'd9;
        cmd(3'b010, 5'd21);
        chk("R9 set addr1", dac_regs[0], 255);
        chk("R9 set addr14", dac_regs[13], 255);
        chk("R9 set captures", dac_regs[14], 9);
        chk("R9 set sync", sync_err, 1);
        chk("R9 hole", dac_regs[7], 0);
        chk("R9 outcfg kept", out_cfg, 3);
        chk("R9 send kept", send_en, 1);
        cmd(3'b101, 5'd21);
        chk("R9 clear addr6", dac_regs[5], 0);
        chk("R9 clear outcfg kept", out_cfg, 3);
        wr(5'd21, 8'h3C, 8);
        chk("R9 write addr1", dac_regs[0], 8'h3C);
        chk("R9 write addr15", dac_regs[14], 8'h3C);
        chk("R9 write outcfg kept", out_cfg, 3);
        cmd(3'b110, 5'd21);
        chk("R9 default addr5", dac_regs[4], 202);
        chk("R9 default addr15", dac_regs[14], 0);
        chk("R9 default reject kept", reject_hits, 0);
        chk("R9 default outcfg kept", out_cfg, 3);

        // R10 command cuts a write short
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'b001; cmd_addr = 5'd2;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            cmd_valid = 1'b0; data_valid = 1'b1; data_bit = 1'b1;
        end
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'b010; cmd_addr = 5'd12; data_bit = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0; data_bit = 1'b0;
        @(negedge clk);
        data_valid = 1'b0;
        @(negedge clk);
        chk("R10 partial write", dac_regs[1], 8'hE9);
        chk("R10 command applied", dac_regs[11], 255);
        chk("R10 other kept", dac_regs[0], 100);

        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule